// File: doc/BRIEF.md
# Fractional Sample-Period Divider

This block turns a fast reference clock into a one-cycle sample strobe. The average spacing between strobes is a rational number of reference cycles, N/(M+1). Every strobe interval is a whole number of cycles. The spacing alternates between the two integers next to the ratio, so that the long-run average is exact. The strobe paces an audio FIFO pop and a serial audio bus. Software picks N and M+1 as the best rational approximation of the reference frequency divided by the sample rate, within the field limits, and writes both into one 32-bit register.

An accumulator adds the denominator on every enabled cycle. It fires, and subtracts N, whenever the sum reaches N. Writing the register clears the accumulator and starts the sequence again. The run enable input freezes the sequence without losing its phase.

Top module: `frac_period_div`

## Requirements
- R1: While reset is high and on the first cycle after it, `smp_strobe` is 0 and `cfg_q` is 0.
- R2: The register splits into two fields: N in bits 31:8 (24 bits) and M in bits 7:0. The denominator used is D = M+1, from 1 to 256. A write takes effect on the clock edge where `cfg_we` is high, and `cfg_q` shows the written word from the next cycle.
- R3: After a write, when N ≥ D and N ≠ 0, the number of strobes seen after j enabled cycles equals floor(j·D/N).
- R4: Any two consecutive strobes after a write are separated by either floor(N/D) or ceil(N/D) enabled cycles.
- R5: A write clears the accumulator and gives no strobe in the cycle after it. The first strobe then follows the ceil(N/D)-th enabled cycle, even when the write lands in the middle of a run.
- R6: When N = 0 or N < D, no strobe is ever produced.
- R7: A cycle with `run_en` low produces no strobe and leaves the accumulator unchanged, so the sequence carries on from where it paused.
- R8: `smp_strobe` is registered and one cycle wide per step. It is high in the cycle right after an enabled edge whose step reached N. When N = D, it is high after every enabled step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write word: N in bits 31:8, M in bits 7:0 |
| run_en | input | 1 | Enables accumulation on this cycle |
| cfg_q | output | 32 | Current register contents |
| smp_strobe | output | 1 | One-cycle sample strobe |

## Verification
The assertions assume that `cfg_we` and `run_en` are clean, synchronous levels. They also assume that the interval bound is only meaningful between strobes that share the same register value, which is why every write restarts the interval counter they use. The stimulus writes random N and M values, drawn so that valid ratios, ratios below one and N = 0 all occur, and holds `run_en` at random for a stretch of cycles after each write. Directed cases add N = D, a ratio of 1.5, a pause in the middle of a run, a rewrite in the middle of a run, and the largest N with the largest D, so that the accumulator is exercised near its full width.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int FPD_NUM_W = 24;
  localparam int FPD_DEN_W = 8;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ACC  = 2'd1,
    STEP_FIRE = 2'd2
  } fpd_step_e;
endpackage

// File: rtl/fpd_cfg_reg.sv
module fpd_cfg_reg #(
  parameter int NUM_W = fpd_pkg::FPD_NUM_W,
  parameter int DEN_W = fpd_pkg::FPD_DEN_W,
  localparam int REG_W = NUM_W + DEN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] cfg_q,
  output logic [NUM_W-1:0] num,
  output logic [DEN_W:0]   den,
  output logic             valid
);
  logic [NUM_W-1:0] w_num;
  logic [DEN_W:0]   w_den;

  assign w_num = wdata[REG_W-1:DEN_W];
  assign w_den = {1'b0, wdata[DEN_W-1:0]} + {{DEN_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      valid <= 1'b0;
    end else if (we) begin
      cfg_q <= wdata;
      valid <= (w_num != '0) &&
               ({{(NUM_W-DEN_W-1){1'b0}}, w_den} <= w_num);
    end
  end

  assign num = cfg_q[REG_W-1:DEN_W];
  assign den = {1'b0, cfg_q[DEN_W-1:0]} + {{DEN_W{1'b0}}, 1'b1};

  // the register shows the written word one cycle after the write
  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (rst)
    $past(we) |-> cfg_q == $past(wdata));
endmodule

// File: rtl/fpd_accum.sv
module fpd_accum #(
  parameter int NUM_W = fpd_pkg::FPD_NUM_W,
  parameter int DEN_W = fpd_pkg::FPD_DEN_W,
  localparam int ACC_W = NUM_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step_en,
  input  logic             valid,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W:0]   den,
  output logic             fire_q
);
  import fpd_pkg::*;

  logic [NUM_W-1:0] acc;
  logic [ACC_W-1:0] den_x;
  logic [ACC_W-1:0] num_x;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] rem;
  fpd_step_e        step;

  assign den_x = {{(ACC_W-DEN_W-1){1'b0}}, den};
  assign num_x = {1'b0, num};
  assign sum   = {1'b0, acc} + den_x;
  assign rem   = sum - num_x;

  always_comb begin
    if (!(step_en && valid))
      step = STEP_HOLD;
    else if (sum >= num_x)
      step = STEP_FIRE;
    else
      step = STEP_ACC;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc    <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= (step == STEP_FIRE);
      case (step)
        STEP_FIRE: acc <= rem[NUM_W-1:0];
        STEP_ACC:  acc <= sum[NUM_W-1:0];
        default:   acc <= acc;
      endcase
    end
  end

  // ---- checker state: enabled steps since last fire ----
  logic [ACC_W-1:0] gap;
  logic [ACC_W-1:0] gap_n;
  logic             seen;
  logic [ACC_W-1:0] q_lo;
  logic [ACC_W-1:0] q_hi;

  assign gap_n = gap + {{(ACC_W-1){1'b0}}, 1'b1};
  assign q_lo  = num_x / den_x;
  assign q_hi  = (num_x + den_x - {{(ACC_W-1){1'b0}}, 1'b1}) / den_x;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (step == STEP_FIRE) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (step == STEP_ACC) begin
      gap  <= gap_n;
    end
  end

  // accumulator never holds a full period's worth
  assert_acc_bound_R3: assert property (@(posedge clk) disable iff (rst)
    valid |-> ({1'b0, acc} < num_x));

  assert_interval_R4: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_FIRE && seen) |-> (gap_n >= q_lo && gap_n <= q_hi));

  assert_first_fire_R5: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_FIRE && !seen) |-> gap_n == q_hi);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!step_en) && !$past(restart)) |-> ($stable(acc) && !fire_q));
endmodule

// File: rtl/frac_period_div.sv
module frac_period_div #(
  parameter int NUM_W = fpd_pkg::FPD_NUM_W,
  parameter int DEN_W = fpd_pkg::FPD_DEN_W,
  localparam int REG_W = NUM_W + DEN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             run_en,
  output logic [REG_W-1:0] cfg_q,
  output logic             smp_strobe
);
  logic [NUM_W-1:0] num;
  logic [DEN_W:0]   den;
  logic             valid;

  fpd_cfg_reg #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg_q (cfg_q),
    .num   (num),
    .den   (den),
    .valid (valid)
  );

  fpd_accum #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .restart (cfg_we),
    .step_en (run_en),
    .valid   (valid),
    .num     (num),
    .den     (den),
    .fire_q  (smp_strobe)
  );

  // a strobe only follows an enabled, non-write edge
  assert_strobe_src_R8: assert property (@(posedge clk) disable iff (rst)
    smp_strobe |-> ($past(run_en) && !$past(cfg_we)));

  // degenerate ratios never strobe
  assert_no_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    smp_strobe |-> (cfg_q[REG_W-1:DEN_W] != '0 &&
      {1'b0, cfg_q[REG_W-1:DEN_W]} >=
      {{(NUM_W-DEN_W){1'b0}}, {1'b0, cfg_q[DEN_W-1:0]} + {{DEN_W{1'b0}}, 1'b1}}));

  assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_we) |-> !smp_strobe);

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!smp_strobe && cfg_q == '0));
endmodule

// File: tb/test_frac_period_div.sv
`timescale 1ns/1ps
module test_frac_period_div;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic        run_en;
  logic [31:0] cfg_q;
  logic        smp_strobe;

  always #2 clk = ~clk;

  frac_period_div i_frac_period_div (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .run_en(run_en), .cfg_q(cfg_q), .smp_strobe(smp_strobe)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  longint m_n = 0, m_d = 1, m_j = 0, m_last = 0, m_cnt = 0;
  bit     m_seen = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint fl(input longint j);
    return (j * m_d) / m_n;
  endfunction

  function automatic bit m_valid();
    return (m_n != 0) && (m_n >= m_d);
  endfunction

  function automatic longint ceil_q();
    return (m_n + m_d - 1) / m_d;
  endfunction

  task automatic cyc(input bit we, input logic [31:0] d, input bit en);
    longint exp;
    string  tag;
    @(negedge clk);
    cfg_we = we; cfg_wdata = d; run_en = en;
    @(posedge clk); #1;
    if (we) begin
      m_n = longint'(d[31:8]); m_d = longint'(d[7:0]) + 1;
      m_j = 0; m_seen = 0; m_cnt = 0; exp = 0; tag = "R5";
    end else if (en && m_valid()) begin
      m_j++;
      exp = fl(m_j) - fl(m_j - 1);
      tag = (m_j <= ceil_q()) ? "R5" : "R8";
    end else begin
      exp = 0;
      tag = m_valid() ? "R7" : "R6";
    end
    check(longint'(smp_strobe) == exp, tag, longint'(smp_strobe), exp);
    if (we) check(cfg_q == d, "R2", longint'(cfg_q), longint'(d));
    if (smp_strobe) begin
      m_cnt++;
      if (m_seen)
        check((m_j - m_last) >= m_n / m_d && (m_j - m_last) <= ceil_q(),
              "R4", m_j - m_last, m_n / m_d);
      m_seen = 1; m_last = m_j;
    end
  endtask

  task automatic run(input int len, input int en_pct);
    for (int i = 0; i < len; i++)
      cyc(1'b0, cfg_wdata, ($urandom % 100) < en_pct);
    if (m_valid()) check(m_cnt == fl(m_j), "R3", m_cnt, fl(m_j));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; run_en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(smp_strobe == 1'b0, "R1", longint'(smp_strobe), 0);
    check(cfg_q == 32'd0, "R1", longint'(cfg_q), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(smp_strobe == 1'b0 && cfg_q == 32'd0, "R1", longint'(cfg_q), 0);

    // R3 R4: ratio 2.5 with a pause in the middle (R7)
    cyc(1'b1, {24'd10, 8'd3}, 1'b0);
    cyc(1'b0, cfg_wdata, 1'b1);
    for (int i = 0; i < 20; i++) cyc(1'b0, cfg_wdata, 1'b0);
    run(60, 100);
    // N == D: strobe on every enabled step (R8)
    cyc(1'b1, {24'd4, 8'd3}, 1'b1);
    run(30, 100);
    // ratio 1.5: back-to-back strobes allowed
    cyc(1'b1, {24'd3, 8'd1}, 1'b1);
    run(40, 100);
    // R6: N zero, N below D
    cyc(1'b1, {24'd0, 8'd5}, 1'b1);
    run(30, 100);
    cyc(1'b1, {24'd5, 8'd9}, 1'b1);
    run(30, 100);
    // R5: rewrite mid-run
    cyc(1'b1, {24'd7, 8'd2}, 1'b1);
    run(11, 100);
    cyc(1'b1, {24'd9, 8'd3}, 1'b1);
    run(40, 100);
    // random configurations
    for (int k = 0; k < 40; k++) begin
      logic [23:0] n;
      logic [7:0]  mm;
      n  = (k % 9 == 8) ? 24'd0 : 24'(1 + $urandom % 600);
      mm = 8'($urandom % 64);
      cyc(1'b1, {n, mm}, 1'b1);
      run(250, 75);
    end
    // widest N with widest D
    cyc(1'b1, {24'hFFFFFF, 8'd255}, 1'b1);
    run(65540, 100);
    check(m_cnt == 1, "R3", m_cnt, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule